// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one unsigned `WIDTH`-bit operand by another and returns a `WIDTH`-bit quotient and a `WIDTH`-bit remainder. The dividend and the divisor are held in their own registers, and each has a separate capture strobe. A start request begins the division. Each clock cycle then produces one quotient bit. On every step the partial remainder and the next dividend bit are shifted together. The result is compared with the divisor, and the divisor is subtracted only when it fits. The shift, the compare and the conditional subtract all happen in one cycle, so a division takes exactly `WIDTH` working cycles.

The dividend register is reused to hold the quotient. Quotient bits enter it from the right while dividend bits leave it from the left. When the last bit is in, the block raises `done`. It keeps `done`, the quotient and the remainder unchanged for as long as the requester keeps `start` high. Dropping `start` returns the block to idle, where new operands may be captured. Divide-by-zero and signed operands are not handled.

Top module: `restoring_divider`

## Requirements
- R1: After reset is asserted (active low), `done` is 0 and `quotient` and `remainder` are both 0.
- R2: While idle, `dvd_load`=1 at a clock edge captures `dividend_in`, and `dvs_load`=1 captures `divisor_in`. An operand whose strobe is low keeps its previous value. The quotient overwrites the captured dividend, but the captured divisor is kept across divisions.
- R3: `start`=1 in idle begins a division. `done` rises at the `WIDTH+1`-th rising edge counted from, and including, the edge that samples `start`. It is still 0 after the `WIDTH`-th such edge.
- R4: With `done`=1 and a nonzero divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. For example, 140/9 with `WIDTH`=8 gives 15 remainder 5.
- R5: After every step, the partial remainder is smaller than a nonzero divisor.
- R6: While `done`=1 and `start` stays 1, `done`, `quotient` and `remainder` hold. `done` falls at the first edge that samples `start`=0.
- R7: Operand strobes are ignored while a division runs and while `done` is high.
- R8: An operand strobe in the same cycle as the `start` that begins a division is captured, and the new value is used in that division.
- R9: Lowering and raising `start` while a division runs has no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dividend_in | input | WIDTH | Dividend value to capture |
| divisor_in | input | WIDTH | Divisor value to capture |
| dvd_load | input | 1 | Capture strobe for the dividend |
| dvs_load | input | 1 | Capture strobe for the divisor |
| start | input | 1 | Begin request; also holds the result while high |
| quotient | output | WIDTH | Quotient, valid while `done` is 1 |
| remainder | output | WIDTH | Remainder, valid while `done` is 1 |
| done | output | 1 | Division complete |

## Verification
Operand capture and the start of a division can coincide. This happens when a strobe and `start` are both high in the same idle cycle. The bench provokes it by raising both together with operands that differ from those held. It passes only if the result matches the new operands. A second collision is a strobe pulse arriving while a run is in progress or while the result is held. That case is judged in two steps. First, the finished result must be unchanged. Second, a following run that reloads only the dividend must divide by the divisor kept from before.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_RUN  = 2'd1,
        RD_HOLD = 2'd2
    } rdiv_state_e;

endpackage

// File: rtl/rdiv_step.sv
module rdiv_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic             next_bit,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] rem_out,
    output logic             qbit
);
    localparam int SW = WIDTH + 1;

    logic [SW-1:0] shifted;
    logic [SW:0]   trial;

    always_comb begin
        shifted = {rem_in, next_bit};
        trial   = {1'b0, shifted} - {2'b00, divisor};
        // no borrow out of the wide subtract means the divisor fits
        qbit    = ~trial[SW];
        rem_out = qbit ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
    end

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dividend_in,
    input  logic [WIDTH-1:0] divisor_in,
    input  logic             dvd_load,
    input  logic             dvs_load,
    input  logic             capture_en,
    input  logic             clear_rem,
    input  logic             step_en,
    output logic [WIDTH-1:0] quo_out,
    output logic [WIDTH-1:0] rem_out
);
    typedef struct packed {
        logic [WIDTH-1:0] shreg;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] dvs;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;
    logic [WIDTH-1:0] step_rem;
    logic             step_q;

    rdiv_step #(.WIDTH(WIDTH)) u_step (
        .rem_in  (dp_q.rem),
        .next_bit(dp_q.shreg[WIDTH-1]),
        .divisor (dp_q.dvs),
        .rem_out (step_rem),
        .qbit    (step_q)
    );

    always_comb begin
        dp_d = dp_q;
        if (capture_en) begin
            if (dvd_load) dp_d.shreg = dividend_in;
            if (dvs_load) dp_d.dvs   = divisor_in;
        end
        if (clear_rem) dp_d.rem = '0;
        if (step_en) begin
            dp_d.rem   = step_rem;
            dp_d.shreg = {dp_q.shreg[WIDTH-2:0], step_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign quo_out = dp_q.shreg;
    assign rem_out = dp_q.rem;

    assert_rem_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && dp_q.dvs != '0) |=> (dp_q.rem < dp_q.dvs));

    assert_dvs_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(dp_q.dvs));

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic capture_en,
    output logic clear_rem,
    output logic step_en,
    output logic done
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    typedef struct packed {
        rdiv_state_e   st;
        logic [CW-1:0] cnt;
    } ctrl_regs_t;

    ctrl_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            RD_IDLE: if (start) begin
                c_d.st  = RD_RUN;
                c_d.cnt = LAST_STEP;
            end
            RD_RUN: begin
                if (c_q.cnt == '0) c_d.st = RD_HOLD;
                else               c_d.cnt = c_q.cnt - 1'b1;
            end
            RD_HOLD: if (!start) c_d.st = RD_IDLE;
            default: c_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: RD_IDLE, cnt: '0};
        else        c_q <= c_d;
    end

    assign capture_en = (c_q.st == RD_IDLE);
    assign clear_rem  = (c_q.st == RD_IDLE) && start;
    assign step_en    = (c_q.st == RD_RUN);
    assign done       = (c_q.st == RD_HOLD);

    assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == RD_IDLE && start) |=> (c_q.st == RD_RUN && c_q.cnt == LAST_STEP));

    assert_last_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == RD_RUN && c_q.cnt == '0) |=> (c_q.st == RD_HOLD));

    assert_run_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == RD_RUN && c_q.cnt != '0) |=> (c_q.st == RD_RUN));

    assert_hold_while_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == RD_HOLD && start) |=> (c_q.st == RD_HOLD));

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dividend_in,
    input  logic [WIDTH-1:0] divisor_in,
    input  logic             dvd_load,
    input  logic             dvs_load,
    input  logic             start,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             done
);
    logic capture_en, clear_rem, step_en;

    rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .capture_en(capture_en),
        .clear_rem (clear_rem),
        .step_en   (step_en),
        .done      (done)
    );

    rdiv_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .dividend_in(dividend_in),
        .divisor_in (divisor_in),
        .dvd_load   (dvd_load),
        .dvs_load   (dvs_load),
        .capture_en (capture_en),
        .clear_rem  (clear_rem),
        .step_en    (step_en),
        .quo_out    (quotient),
        .rem_out    (remainder)
    );

    assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (done && $stable(quotient) && $stable(remainder)));

    assert_reset_values_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!done && quotient == '0 && remainder == '0));

endmodule

// File: tb/sim_restoring_divider.sv
module sim_restoring_divider;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] dividend_in = '0, divisor_in = '0;
    logic         dvd_load = 1'b0, dvs_load = 1'b0, start = 1'b0;
    logic [W-1:0] quotient, remainder;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    restoring_divider #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dividend_in(dividend_in), .divisor_in(divisor_in),
        .dvd_load(dvd_load), .dvs_load(dvs_load), .start(start),
        .quotient(quotient), .remainder(remainder), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present operands, then start. If with_start, the strobes go up together with start (R8).
    // mid_strobe pulses the strobes with junk during the run (R7).
    // mid_start drops and re-raises start during the run (R9).
    task automatic run_div(input int a, input int b, input bit ld_a, input bit ld_b,
                           input bit with_start, input bit mid_strobe, input bit mid_start,
                           input int exp_q, input int exp_r, input string tag);
        @(negedge clk);
        dividend_in = W'(a); divisor_in = W'(b);
        dvd_load = ld_a; dvs_load = ld_b;
        if (!with_start) begin
            @(negedge clk);
            dvd_load = 1'b0; dvs_load = 1'b0;
        end
        start = 1'b1;
        @(posedge clk);                 // edge sampling start
        @(negedge clk);
        dvd_load = 1'b0; dvs_load = 1'b0;
        dividend_in = W'(a + 37); divisor_in = W'(b + 3);
        if (mid_start) start = 1'b0;
        for (int k = 1; k < W; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 2 && mid_strobe) begin dvd_load = 1'b1; dvs_load = 1'b1; end
            if (k == 3) begin dvd_load = 1'b0; dvs_load = 1'b0; end
            if (k == 3 && mid_start) start = 1'b1;
            if (k == 4 && mid_start) start = 1'b0;
            if (k == 5 && mid_start) start = 1'b1;
        end
        start = 1'b1;
        check(done == 1'b0, {"R3 done early ", tag}, done, 0);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, {"R3 done late ", tag}, done, 1);
        check(quotient == W'(exp_q), {"R4 quotient ", tag}, quotient, exp_q);
        check(remainder == W'(exp_r), {"R4 remainder ", tag}, remainder, exp_r);
    endtask

    // Hold the result a few cycles (optionally strobing junk, R7), then release.
    task automatic hold_and_release(input int exp_q, input int exp_r, input bit strobe, input string tag);
        dividend_in = W'(exp_q + 11); divisor_in = 8'd2;
        dvd_load = strobe; dvs_load = strobe;
        repeat (3) @(posedge clk);
        @(negedge clk);
        dvd_load = 1'b0; dvs_load = 1'b0;
        check(done == 1'b1, {"R6 done held ", tag}, done, 1);
        check(quotient == W'(exp_q) && remainder == W'(exp_r), {"R6/R7 result held ", tag},
              quotient, exp_q);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, {"R6 done falls ", tag}, done, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(done == 1'b0, "R1 done", done, 0);
        check(quotient == '0, "R1 quotient", quotient, 0);
        check(remainder == '0, "R1 remainder", remainder, 0);
    endtask

    task automatic t_patterns;
        int a_list [6] = '{140, 255, 0, 7, 200, 255};
        int b_list [6] = '{9, 1, 7, 255, 200, 16};
        for (int i = 0; i < 6; i++) begin
            run_div(a_list[i], b_list[i], 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                    a_list[i] / b_list[i], a_list[i] % b_list[i], "R2 pattern");
            hold_and_release(a_list[i] / b_list[i], a_list[i] % b_list[i], 1'b0, "pattern");
        end
    endtask

    task automatic t_busy_strobes;
        // R7: strobes during the run and during hold are dropped
        run_div(140, 9, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 15, 5, "R7 run strobe");
        hold_and_release(15, 5, 1'b1, "R7 hold strobe");
        // R2/R7: divisor 9 kept; reload only the dividend
        run_div(100, 77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 100 / 9, 100 % 9, "R2 kept divisor");
        hold_and_release(100 / 9, 100 % 9, 1'b0, "kept");
    endtask

    task automatic t_collision;
        // R8: strobes in the same cycle as start
        run_div(173, 12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 173 / 12, 173 % 12, "R8 same cycle");
        hold_and_release(173 / 12, 173 % 12, 1'b0, "R8");
    endtask

    task automatic t_start_toggle;
        run_div(250, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 250 / 7, 250 % 7, "R9 start toggled");
        hold_and_release(250 / 7, 250 % 7, 1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_busy_strobes();
        t_collision();
        t_start_toggle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule